// File: doc/BRIEF.md
# Half-Duplex Transmit Turnaround Sequencer

This block runs the modem handshake that comes before a transmit on a half-duplex line. A transmit start raises request-to-send. A timeout timer then bounds the wait for clear-to-send. Once clear-to-send is seen, a second timer adds a programmable pretransmit delay, and only after that delay does the block enable data transfer. Both timers count a 1 ms tick input. They are loaded with the values present at the transmit start, and a value of zero turns a timer off. A typical pretransmit setting is about 9 ticks.

When a transfer ends, the block stays in transmit mode and keeps request-to-send high. The next transmit start in the chain therefore skips both timers and enables transfer at once. A non-transmit operation start returns the block to idle and drops request-to-send. If clear-to-send does not arrive before the timeout runs out, the block pulses an exception request, sets a sticky modem-error flag and drops request-to-send.

Top module: `tat_turnaround`

## Requirements
- R1: After reset, rts_o, xfer_en_o, exc_req_o and modem_err_o are all 0.
- R2: A cycle with start_i=1 and xmit_i=1 (1 means transmit) while idle sets rts_o to 1 from the next cycle, and the block waits for cts_i.
- R3: If cts_i is 1 in the wait state and the pretransmit value is nonzero, xfer_en_o rises in the cycle after the pretransmit value-th tick_i. Ticks are counted from the cycle after the cts_i cycle, and a tick in the cts_i cycle itself is not counted.
- R4: If the pretransmit value is zero, xfer_en_o rises in the cycle after cts_i is seen in the wait state.
- R5: If the timeout value is N>0 and cts_i stays 0, then on the N-th tick_i in the wait state the next cycle shows exc_req_o=1 for exactly one cycle, modem_err_o=1 and rts_o=0. This includes the full-scale value.
- R6: A timeout value of zero makes the wait for cts_i unbounded, and no exception is raised however many ticks pass.
- R7: When cts_i and the final timeout tick arrive in the same cycle, cts_i wins and no exception is raised.
- R8: done_i during transfer clears xfer_en_o while rts_o stays 1. xfer_en_o is never 1 while rts_o is 0.
- R9: A transmit start while transfer has ended with rts_o still high sets xfer_en_o in the next cycle, with no timer and no cts_i needed.
- R10: A cycle with start_i=1 and xmit_i=0 sends the block to idle from any state: rts_o=0 and xfer_en_o=0 from the next cycle.
- R11: modem_err_o stays 1 until the next transmit start from idle, and it reads 0 in the cycle after that start.
- R12: A transmit start during the wait, pretransmit or transfer states is ignored. Timer values and progress stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse every 1 ms |
| start_i | input | 1 | Operation start pulse |
| xmit_i | input | 1 | Qualifies start_i: 1 for transmit, 0 for any other operation |
| t1_val_i | input | TMR_W | Pretransmit delay in ticks, 0 disables |
| t2_val_i | input | TMR_W | Clear-to-send timeout in ticks, 0 disables |
| cts_i | input | 1 | Clear-to-send from the modem |
| done_i | input | 1 | Pulse at the end of the current transfer |
| rts_o | output | 1 | Request-to-send to the modem |
| xfer_en_o | output | 1 | Data transfer enabled |
| exc_req_o | output | 1 | One-cycle exception request on timeout |
| modem_err_o | output | 1 | Sticky modem interface error status |

## Verification
The bench builds the block with TMR_W=4. This makes the full-scale timer value 15 ticks, so a timeout and a pretransmit delay at full scale each complete within a few dozen cycles. With that width the bench can reach the top-of-range decrement boundary. It can also reach the same-cycle race between clear-to-send and the last timeout tick, and aborts in the middle of the delay. A behavioural model with plain integers tracks every cycle, and directed checks pin the exact cycle at which each output turns.

// File: rtl/tat_pkg.sv
package tat_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_CTS,
    ST_PRE_DLY,
    ST_XFER,
    ST_HOLD
  } tat_state_e;
endpackage

// File: rtl/tat_tick_timer.sv
module tat_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         run_i,
  input  logic         tick_i,
  output logic         hit_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (load_i)                          cnt_q <= load_val_i;
    else if (run_i && tick_i && cnt_q != '0)  cnt_q <= cnt_q - ONE;
  end

  // zero count never hits: disabled timer
  assign hit_o = run_i && tick_i && (cnt_q == ONE);
endmodule

// File: rtl/tat_fsm.sv
module tat_fsm
  import tat_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       xmit_i,
  input  logic       cts_i,
  input  logic       done_i,
  input  logic       t1_zero_i,
  input  logic       t1_hit_i,
  input  logic       t2_hit_i,
  output tat_state_e state_o,
  output logic       t2_load_o,
  output logic       t2_run_o,
  output logic       t1_load_o,
  output logic       t1_run_o,
  output logic       exc_o,
  output logic       merr_o
);
  tat_state_e st_q, st_d;
  logic       exc_q, exc_d;
  logic       merr_q, merr_d;
  logic       go_tx, go_other;

  assign go_tx    = start_i && xmit_i;
  assign go_other = start_i && !xmit_i;

  always_comb begin
    st_d      = st_q;
    exc_d     = 1'b0;
    merr_d    = merr_q;
    t2_load_o = 1'b0;
    t1_load_o = 1'b0;
    if (go_other) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (go_tx) begin
          st_d      = ST_WAIT_CTS;
          t2_load_o = 1'b1;
          merr_d    = 1'b0;
        end
        ST_WAIT_CTS: begin
          if (cts_i) begin
            if (t1_zero_i) st_d = ST_XFER;
            else begin
              st_d      = ST_PRE_DLY;
              t1_load_o = 1'b1;
            end
          end else if (t2_hit_i) begin
            st_d   = ST_IDLE;
            exc_d  = 1'b1;
            merr_d = 1'b1;
          end
        end
        ST_PRE_DLY: if (t1_hit_i) st_d = ST_XFER;
        ST_XFER:    if (done_i)   st_d = ST_HOLD;
        ST_HOLD:    if (go_tx)    st_d = ST_XFER;
        default:    st_d = ST_IDLE;
      endcase
    end
  end

  assign t2_run_o = (st_q == ST_WAIT_CTS) && !cts_i;
  assign t1_run_o = (st_q == ST_PRE_DLY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      exc_q  <= 1'b0;
      merr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      exc_q  <= exc_d;
      merr_q <= merr_d;
    end
  end

  assign state_o = st_q;
  assign exc_o   = exc_q;
  assign merr_o  = merr_q;
endmodule

// File: rtl/tat_turnaround.sv
module tat_turnaround
  import tat_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             xmit_i,
  input  logic [TMR_W-1:0] t1_val_i,
  input  logic [TMR_W-1:0] t2_val_i,
  input  logic             cts_i,
  input  logic             done_i,
  output logic             rts_o,
  output logic             xfer_en_o,
  output logic             exc_req_o,
  output logic             modem_err_o
);
  tat_state_e       state;
  logic             t2_load, t2_run, t2_hit;
  logic             t1_load, t1_run, t1_hit;
  logic [TMR_W-1:0] t1_keep_q;

  // pretransmit value captured with the timeout value at transmit start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      t1_keep_q <= '0;
    else if (t2_load) t1_keep_q <= t1_val_i;
  end

  tat_tick_timer #(.W(TMR_W)) u_cts_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t2_load),
    .load_val_i (t2_val_i),
    .run_i      (t2_run),
    .tick_i     (tick_i),
    .hit_o      (t2_hit)
  );

  tat_tick_timer #(.W(TMR_W)) u_pre_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t1_load),
    .load_val_i (t1_keep_q),
    .run_i      (t1_run),
    .tick_i     (tick_i),
    .hit_o      (t1_hit)
  );

  tat_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .xmit_i    (xmit_i),
    .cts_i     (cts_i),
    .done_i    (done_i),
    .t1_zero_i (t1_keep_q == '0),
    .t1_hit_i  (t1_hit),
    .t2_hit_i  (t2_hit),
    .state_o   (state),
    .t2_load_o (t2_load),
    .t2_run_o  (t2_run),
    .t1_load_o (t1_load),
    .t1_run_o  (t1_run),
    .exc_o     (exc_req_o),
    .merr_o    (modem_err_o)
  );

  assign rts_o     = (state != ST_IDLE);
  assign xfer_en_o = (state == ST_XFER);
endmodule

// File: rtl/tat_turnaround_chk.sv
module tat_turnaround_chk
  import tat_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       xmit_i,
  input logic       cts_i,
  input logic       done_i,
  input logic       rts_o,
  input logic       xfer_en_o,
  input logic       exc_req_o,
  input logic       modem_err_o,
  input tat_state_e state_i
);
  p_rts_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rts_o) |-> $past(start_i && xmit_i));

  p_exc_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> (modem_err_o && !rts_o));

  p_exc_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |=> !exc_req_o);

  p_cts_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_WAIT_CTS && cts_i && !(start_i && !xmit_i)) |=> (!exc_req_o && rts_o));

  p_xfer_rts_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_en_o |-> rts_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_XFER && done_i && !start_i) |=> (rts_o && !xfer_en_o));

  p_chain_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_HOLD && start_i && xmit_i) |=> xfer_en_o);

  p_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !xmit_i) |=> (!rts_o && !xfer_en_o));

  p_err_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && start_i && xmit_i) |=> (!modem_err_o && rts_o));
endmodule

bind tat_turnaround tat_turnaround_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .xmit_i      (xmit_i),
  .cts_i       (cts_i),
  .done_i      (done_i),
  .rts_o       (rts_o),
  .xfer_en_o   (xfer_en_o),
  .exc_req_o   (exc_req_o),
  .modem_err_o (modem_err_o),
  .state_i     (state)
);

// File: tb/tb_tat_turnaround.sv
`timescale 1ns/1ps
module tb_tat_turnaround;
  localparam int TW = 4;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          tick = 1'b0, start = 1'b0, xmit = 1'b0, cts = 1'b0, done = 1'b0;
  logic [TW-1:0] t1v = '0, t2v = '0;
  logic          rts, xen, exc, merr;
  bit            fin = 1'b0;
  int            n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  tat_turnaround #(.TMR_W(TW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_i(start), .xmit_i(xmit),
    .t1_val_i(t1v), .t2_val_i(t2v), .cts_i(cts), .done_i(done),
    .rts_o(rts), .xfer_en_o(xen), .exc_req_o(exc), .modem_err_o(merr)
  );

  task automatic expect_bit(input string tag, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural model: 0 idle, 1 wait cts, 2 pre delay, 3 transfer, 4 hold
  int m_st = 0, m_t2 = 0, m_t1 = 0, m_t1keep = 0;
  bit m_exc = 1'b0, m_err = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_t2 = 0; m_t1 = 0; m_t1keep = 0; m_exc = 1'b0; m_err = 1'b0;
    end else begin
      m_exc = 1'b0;
      if (start && !xmit) m_st = 0;
      else begin
        case (m_st)
          0: begin
            if (start && xmit) begin
              m_st = 1; m_t2 = int'(t2v); m_t1keep = int'(t1v); m_err = 1'b0;
            end
          end
          1: begin
            if (cts) begin
              if (m_t1keep == 0) m_st = 3;
              else begin m_st = 2; m_t1 = m_t1keep; end
            end else if (tick && m_t2 != 0) begin
              m_t2--;
              if (m_t2 == 0) begin m_st = 0; m_err = 1'b1; m_exc = 1'b1; end
            end
          end
          2: begin
            if (tick) begin
              m_t1--;
              if (m_t1 == 0) m_st = 3;
            end
          end
          3: if (done) m_st = 4;
          4: if (start && xmit) m_st = 3;
          default: m_st = 0;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      expect_bit("R2",  "rts_o",       rts,  m_st != 0);
      expect_bit("R3",  "xfer_en_o",   xen,  m_st == 3);
      expect_bit("R5",  "exc_req_o",   exc,  m_exc);
      expect_bit("R11", "modem_err_o", merr, m_err);
    end
  end

  task automatic cyc(input logic st, input logic xm, input logic tk, input logic dn);
    start = st; xmit = xm; tick = tk; done = dn;
    @(negedge clk);
    start = 1'b0; tick = 1'b0; done = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 1'b0, 1'b1, 1'b0);
      cyc(1'b0, 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    expect_bit("R1", "rts_o", rts, 1'b0);
    expect_bit("R1", "xfer_en_o", xen, 1'b0);
    expect_bit("R1", "exc_req_o", exc, 1'b0);
    expect_bit("R1", "modem_err_o", merr, 1'b0);
    rst_n = 1'b1;
    idle(2);

    // R2/R3: full handshake, then R8 hold, R9 chain, R10 abort
    t2v = 4'd5; t1v = 4'd3;
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    expect_bit("R2", "rts after start", rts, 1'b1);
    ticks(2);
    expect_bit("R2", "waiting xfer_en", xen, 1'b0);
    cts = 1'b1;
    cyc(1'b0, 1'b0, 1'b1, 1'b0);  // tick with cts not counted
    expect_bit("R3", "pre delay start", xen, 1'b0);
    ticks(2);
    expect_bit("R3", "pre delay 2 ticks", xen, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    expect_bit("R3", "pre delay done", xen, 1'b1);
    cts = 1'b0;
    idle(2);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    expect_bit("R8", "xfer_en after done", xen, 1'b0);
    expect_bit("R8", "rts after done", rts, 1'b1);
    ticks(3);
    expect_bit("R8", "rts held", rts, 1'b1);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    expect_bit("R9", "chained xfer_en", xen, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    expect_bit("R10", "rts after abort", rts, 1'b0);
    expect_bit("R10", "xfer_en after abort", xen, 1'b0);

    // R5 timeout, R11 sticky error
    t2v = 4'd3; t1v = 4'd0;
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    ticks(2);
    expect_bit("R5", "no early exc", exc, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    expect_bit("R5", "exc on expiry", exc, 1'b1);
    expect_bit("R5", "err on expiry", merr, 1'b1);
    expect_bit("R5", "rts dropped", rts, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    expect_bit("R5", "exc one cycle", exc, 1'b0);
    idle(3);
    expect_bit("R11", "err sticky", merr, 1'b1);
    t2v = 4'd0;
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    expect_bit("R11", "err cleared", merr, 1'b0);

    // R6 disabled timeout, R4 zero pretransmit delay
    ticks(20);
    expect_bit("R6", "still waiting", rts, 1'b1);
    expect_bit("R6", "no error", merr, 1'b0);
    cts = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    expect_bit("R4", "immediate xfer", xen, 1'b1);
    cts = 1'b0;
    cyc(1'b1, 1'b0, 1'b0, 1'b0);

    // R12 restart during wait ignored
    t2v = 4'd2; t1v = 4'd0;
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    ticks(1);
    t2v = 4'd9;
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    expect_bit("R12", "rts kept", rts, 1'b1);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    expect_bit("R12", "original timeout kept", exc, 1'b1);

    // R7 cts with final tick
    t2v = 4'd2;
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    ticks(1);
    cts = 1'b1;
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    expect_bit("R7", "no exc", exc, 1'b0);
    expect_bit("R7", "xfer enabled", xen, 1'b1);
    cts = 1'b0;
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    expect_bit("R12", "start in xfer ignored", xen, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    expect_bit("R8", "hold", xen, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);

    // R10 abort during pretransmit delay
    t2v = 4'd4; t1v = 4'd5;
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    cts = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cts = 1'b0;
    ticks(2);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    expect_bit("R10", "abort in delay", rts, 1'b0);
    ticks(5);
    expect_bit("R10", "no late xfer", xen, 1'b0);

    // full-scale values
    t2v = 4'd15; t1v = 4'd15;
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    ticks(14);
    expect_bit("R5", "full scale no exc", exc, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    expect_bit("R5", "full scale exc", exc, 1'b1);
    t2v = 4'd0;
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    cts = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cts = 1'b0;
    ticks(14);
    expect_bit("R3", "full scale delay", xen, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    expect_bit("R3", "full scale delay done", xen, 1'b1);
    idle(2);

    fin = 1'b1;
    summary();
    $finish;
  end
endmodule